// File: doc/BRIEF.md
# Per-Channel DMA Request Queue Manager

This block sits between an external requester and eight DMA transfer engines. Each request arrives as a 64-bit word with a strobe. A 3-bit destination field in the word picks one of eight channels. Channel 0 has no storage: its request is forwarded in the same cycle it arrives. Channels 1 to 7 each buffer up to four requests in arrival order. Each of these channels offers its oldest request to its engine, and the engine removes that request with a pop strobe.

A queue can be emptied in two ways. The first is a reserved command pattern carried on the request word, which names the channel to empty. The second is a per-channel software clear bit, which drops back to zero by itself one cycle after it is written. For status readback, every channel shows a pending flag, an occupancy count and a sticky overflow flag.

Top module: `dma_reqq_top`

## Requirements
- R1: Word fields: destination channel is bits 50:48; the word is an empty-queue command when bits 47:45 = 110, bits 44:43 = 00, bits 42:41 = 11 and the selector nibble in bits 55:52 is 1 to 8. The command targets channel (nibble − 1). Any other word is an ordinary request.
- R2: Channel 0 holds no storage. `chan_pend[0]` is high in the same cycle that `req_valid` is high with an ordinary request for channel 0, and `chan_word` slice 0 equals `req_word`. Its occupancy reads 0, its pop strobe has no effect, and its overflow flag never sets.
- R3: Channels 1 to 7 each hold up to 4 requests, first in first out. `chan_word` slice c always shows the oldest held request.
- R4: An accepted request shows in occupancy and pending after the next rising edge. A pop while the queue is non-empty removes the oldest entry at that edge. A pop on an empty queue has no effect.
- R5: A request for a queue holding 4 entries, with no pop in the same cycle, is dropped and sets that channel's `ovf_flag`. The flag stays set until reset. If a pop arrives in the same cycle, the request is accepted.
- R6: An empty-queue command empties its target queue at the next edge and is never stored as a request. A command that targets channel 0 changes nothing. A selector nibble of 0 or 9 to 15 makes the word an ordinary request.
- R7: A high `clr_wr[c]` at an edge sets `clr_bits[c]`. That bit reads 0 one cycle later unless it is written again. Channel c's queue is empty after the edge at which `clr_bits[c]` is 1.
- R8: An empty-queue action (command or clear bit) takes priority over a pop and over a new request to the same channel at the same edge. The queue ends empty.
- R9: For channels 1 to 7, `chan_pend[c]` is 1 exactly when the 3-bit occupancy in `chan_occ[3c+2:3c]` is non-zero.
- R10: After reset, all queues are empty and all overflow and clear bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request word strobe |
| req_word | input | 64 | Request word |
| chan_pop | input | 8 | Per-channel pop from the transfer engine |
| clr_wr | input | 8 | Per-channel write of 1 to the queue clear bit |
| chan_pend | output | 8 | Request available per channel |
| chan_word | output | 512 | Oldest request per channel, 64 bits each, channel c at bits 64c+63:64c |
| chan_occ | output | 24 | Occupancy per channel, 3 bits each |
| ovf_flag | output | 8 | Sticky overflow per channel |
| clr_bits | output | 8 | Queue clear bit readback |

## Verification
The assertions check four things on every cycle: occupancy stays within its bound, an empty-queue action always leaves the count at zero, an accepted request raises the count by one, and channel 0 is only pending while a strobe is present. They also check that the clear bit pulses for one cycle and that an overflow flag rises only after a push into a full queue. First-in first-out ordering, the decoding of the command nibble and its out-of-range values, and collisions of an empty-queue action with a pop or a push can only be shown by the bench scenarios. There, a behavioural model built from queues is compared against every output on every clock.

// File: rtl/dma_reqq_pkg.sv
package dma_reqq_pkg;
    localparam int NUM_CH  = 8;
    localparam int Q_DEPTH = 4;
    localparam int REQ_W   = 64;

    // Bit positions that the decoder relies on
    localparam int DEST_LSB  = 48;
    localparam int SEL_LSB   = 52;
    localparam int XSIZE_LSB = 45;
    localparam int FMT_LSB   = 43;
    localparam int MODE_LSB  = 41;

    localparam logic [2:0] XSIZE_FLUSH = 3'b110;
    localparam logic [1:0] FMT_FLUSH   = 2'b00;
    localparam logic [1:0] MODE_FLUSH  = 2'b11;

    typedef struct packed {
        logic [3:0] sel_nib;
        logic [2:0] xsize;
        logic [1:0] fmt;
        logic [1:0] mode;
        logic [2:0] dest;
    } req_hdr_t;

    function automatic logic is_flush_cmd(input req_hdr_t h, input int nch);
        return (h.xsize == XSIZE_FLUSH) && (h.fmt == FMT_FLUSH) &&
               (h.mode == MODE_FLUSH) && (h.sel_nib != 4'd0) &&
               (int'(h.sel_nib) <= nch);
    endfunction
endpackage

// File: rtl/dma_reqq_decode.sv
module dma_reqq_decode
    import dma_reqq_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic           req_valid,
    input  req_hdr_t       hdr,
    output logic [NCH-1:0] push_vec,
    output logic [NCH-1:0] flush_vec
);
    logic cmd;

    always_comb begin
        cmd       = is_flush_cmd(hdr, NCH);
        push_vec  = '0;
        flush_vec = '0;
        if (req_valid && !cmd)
            push_vec = NCH'(1) << hdr.dest;
        if (req_valid && cmd)
            flush_vec = NCH'(1) << (hdr.sel_nib - 4'd1);
    end

    // R6: a command word never produces a store strobe
    always_comb begin
        a_r6_cmd_not_stored: assert (!(|push_vec && |flush_vec));
    end
endmodule

// File: rtl/dma_reqq_fifo.sv
module dma_reqq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_set
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_p, wr_p;
    logic [CNT_W-1:0] cnt_q;
    logic             full, eff_pop, do_push;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        full    = (cnt_q == CNT_W'(DEPTH));
        eff_pop = pop && (cnt_q != '0);
        do_push = push && (!full || eff_pop);
        ovf_set = push && !flush && full && !eff_pop;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_p  <= '0;
            wr_p  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_p <= bump(wr_p);
            if (eff_pop) rd_p <= bump(rd_p);
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(eff_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush && do_push)
            mem[wr_p] <= din;
    end

    assign head = mem[rd_p];
    assign cnt  = cnt_q;

    // R3: occupancy bound
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));
    // R6/R7/R8: an empty-queue action wins over pop and push
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> cnt_q == '0);
    // R4: accepted request grows the count by one
    a_r4_push_grows: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && !full) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/dma_reqq_top.sv
module dma_reqq_top
    import dma_reqq_pkg::*;
#(
    parameter int NCH   = NUM_CH,
    parameter int DEPTH = Q_DEPTH,
    parameter int W     = REQ_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [W-1:0]       req_word,
    input  logic [NCH-1:0]     chan_pop,
    input  logic [NCH-1:0]     clr_wr,
    output logic [NCH-1:0]     chan_pend,
    output logic [NCH*W-1:0]   chan_word,
    output logic [NCH*CNT_W-1:0] chan_occ,
    output logic [NCH-1:0]     ovf_flag,
    output logic [NCH-1:0]     clr_bits
);
    req_hdr_t       hdr;
    logic [NCH-1:0] push_vec, flush_vec, flush_all, ovf_set;
    logic [NCH-1:0] clr_q, ovf_q;
    logic [1:0]     unused_ch0;

    assign hdr = '{sel_nib: req_word[SEL_LSB +: 4],
                   xsize:   req_word[XSIZE_LSB +: 3],
                   fmt:     req_word[FMT_LSB +: 2],
                   mode:    req_word[MODE_LSB +: 2],
                   dest:    req_word[DEST_LSB +: 3]};

    dma_reqq_decode #(.NCH(NCH)) u_dec (
        .req_valid (req_valid),
        .hdr       (hdr),
        .push_vec  (push_vec),
        .flush_vec (flush_vec)
    );

    // Clear bit: holds the written 1 for one cycle, then drops
    always_ff @(posedge clk) begin
        if (rst) clr_q <= '0;
        else     clr_q <= clr_wr;
    end

    assign flush_all = flush_vec | clr_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c == 0) begin : g_pass
            assign chan_pend[c]               = push_vec[c];
            assign chan_word[c*W +: W]         = req_word;
            assign chan_occ[c*CNT_W +: CNT_W]  = '0;
            assign ovf_set[c]                  = 1'b0;
        end else begin : g_q
            logic [CNT_W-1:0] occ;
            dma_reqq_fifo #(.DEPTH(DEPTH), .W(W)) u_q (
                .clk     (clk),
                .rst     (rst),
                .push    (push_vec[c]),
                .pop     (chan_pop[c]),
                .flush   (flush_all[c]),
                .din     (req_word),
                .head    (chan_word[c*W +: W]),
                .cnt     (occ),
                .ovf_set (ovf_set[c])
            );
            assign chan_occ[c*CNT_W +: CNT_W] = occ;
            assign chan_pend[c]               = (occ != '0);

            // R5: overflow rises only after a push into a full queue
            a_r5_ovf_cause: assert property (@(posedge clk) disable iff (rst)
                $rose(ovf_q[c]) |-> $past(push_vec[c] && occ == CNT_W'(DEPTH)));
        end

        // R7: clear bit self-clears
        a_r7_clr_pulse: assert property (@(posedge clk) disable iff (rst)
            (clr_q[c] && !clr_wr[c]) |=> !clr_q[c]);
    end

    assign unused_ch0 = {chan_pop[0], flush_all[0]};

    always_ff @(posedge clk) begin
        if (rst) ovf_q <= '0;
        else     ovf_q <= ovf_q | ovf_set;
    end

    assign ovf_flag = ovf_q;
    assign clr_bits = clr_q;

    // R2: channel 0 only pending while a strobe is present
    a_r2_ch0_live: assert property (@(posedge clk) disable iff (rst)
        chan_pend[0] |-> (req_valid && req_word[DEST_LSB +: 3] == 3'd0));
endmodule

// File: tb/tb_dma_reqq_top.sv
module tb_dma_reqq_top;
    localparam int NCH = 8, DEPTH = 4, W = 64, CW = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst, req_valid;
    logic [W-1:0]   req_word;
    logic [NCH-1:0] chan_pop, clr_wr;
    logic [NCH-1:0] chan_pend, ovf_flag, clr_bits;
    logic [NCH*W-1:0]  chan_word;
    logic [NCH*CW-1:0] chan_occ;

    dma_reqq_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_word(req_word),
        .chan_pop(chan_pop), .clr_wr(clr_wr), .chan_pend(chan_pend),
        .chan_word(chan_word), .chan_occ(chan_occ), .ovf_flag(ovf_flag),
        .clr_bits(clr_bits)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    logic [W-1:0] mq [NCH][$];
    bit mclr [NCH];
    bit movf [NCH];

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] mkreq(input int ch, input logic [15:0] pl);
        logic [W-1:0] w = '0;
        w[50:48] = ch[2:0];
        w[47:45] = 3'b010;
        w[15:0]  = pl;
        return w;
    endfunction

    function automatic logic [W-1:0] mkcmd(input int nib, input int dest);
        logic [W-1:0] w = '0;
        w[47:45] = 3'b110; w[44:43] = 2'b00; w[42:41] = 2'b11;
        w[55:52] = nib[3:0];
        w[50:48] = dest[2:0];
        w[15:0]  = 16'hC0DE;
        return w;
    endfunction

    function automatic bit is_cmd(input logic [W-1:0] w);
        return w[47:45] == 3'b110 && w[44:43] == 2'b00 && w[42:41] == 2'b11 &&
               w[55:52] >= 4'd1 && w[55:52] <= 4'd8;
    endfunction

    function automatic int occ_of(input int c);
        return int'(chan_occ[c*CW +: CW]);
    endfunction

    task automatic check_ch0();
        bit exp = req_valid && !is_cmd(req_word) && req_word[50:48] == 3'd0;
        chk("R2", "ch0 pend", chan_pend[0], exp);
        if (exp) chk("R2", "ch0 word", chan_word[W-1:0], req_word);
        chk("R2", "ch0 occ", occ_of(0), 0);
        chk("R2", "ch0 ovf", ovf_flag[0], 0);
    endtask

    task automatic compare_all();
        check_ch0();
        for (int c = 1; c < NCH; c++) begin
            chk("R9", $sformatf("ch%0d occ", c), occ_of(c), mq[c].size());
            chk("R9", $sformatf("ch%0d pend", c), chan_pend[c], mq[c].size() != 0);
            if (mq[c].size() != 0)
                chk("R3", $sformatf("ch%0d head", c), chan_word[c*W +: W], mq[c][0]);
            chk("R5", $sformatf("ch%0d ovf", c), ovf_flag[c], movf[c]);
        end
        for (int c = 0; c < NCH; c++)
            chk("R7", $sformatf("ch%0d clr", c), clr_bits[c], mclr[c]);
    endtask

    task automatic model_step(input bit v, input logic [W-1:0] w, input logic [NCH-1:0] pops, input logic [NCH-1:0] clrs);
        for (int c = 1; c < NCH; c++) begin
            bit fl   = mclr[c] || (v && is_cmd(w) && int'(w[55:52]) - 1 == c);
            bit push = v && !is_cmd(w) && int'(w[50:48]) == c;
            int pre  = mq[c].size();
            bit ep   = pops[c] && pre > 0;
            if (fl) mq[c].delete();
            else begin
                if (ep) void'(mq[c].pop_front());
                if (push) begin
                    if (pre < DEPTH || ep) mq[c].push_back(w);
                    else movf[c] = 1;
                end
            end
        end
        for (int c = 0; c < NCH; c++) mclr[c] = clrs[c];
    endtask

    task automatic cyc(input bit v, input logic [W-1:0] w, input logic [NCH-1:0] pops, input logic [NCH-1:0] clrs);
        req_valid = v; req_word = w; chan_pop = pops; clr_wr = clrs;
        #1 check_ch0();
        @(posedge clk);
        model_step(v, w, pops, clrs);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(); cyc(0, '0, '0, '0); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_word = '0; chan_pop = '0; clr_wr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        for (int c = 0; c < NCH; c++) begin mq[c].delete(); mclr[c] = 0; movf[c] = 0; end
        // R10: reset state
        for (int c = 1; c < NCH; c++) chk("R10", "occ after reset", occ_of(c), 0);
        chk("R10", "ovf after reset", ovf_flag, '0);
        chk("R10", "clr after reset", clr_bits, '0);

        // R3/R4: order on ch1
        cyc(1, mkreq(1, 16'h0011), '0, '0);
        chk("R4", "ch1 occ after one push", occ_of(1), 1);
        cyc(1, mkreq(1, 16'h0012), '0, '0);
        cyc(1, mkreq(1, 16'h0013), '0, '0);
        cyc(0, '0, 8'h02, '0);
        chk("R3", "ch1 second entry at head", chan_word[W +: 16], 16'h0012);
        cyc(0, '0, 8'h02, '0);
        cyc(0, '0, 8'h02, '0);
        cyc(0, '0, 8'h02, '0);
        chk("R4", "pop on empty leaves zero", occ_of(1), 0);

        // R5: overflow on ch2, then push with pop on full
        for (int i = 0; i < 5; i++) cyc(1, mkreq(2, 16'h0200 + 16'(i)), '0, '0);
        chk("R5", "ch2 overflow set", ovf_flag[2], 1);
        chk("R5", "ch2 holds four", occ_of(2), 4);
        cyc(1, mkreq(2, 16'h02FF), 8'h04, '0);
        chk("R5", "push with pop on full accepted", occ_of(2), 4);
        idle(); idle();
        chk("R5", "ch2 overflow sticky", ovf_flag[2], 1);

        // R2: channel 0 pass-through, pop ignored
        cyc(1, mkreq(0, 16'h0A0A), 8'h01, '0);
        cyc(1, mkreq(0, 16'h0B0B), '0, '0);
        idle();

        // R1/R6: empty-queue command to ch3 (nibble 4)
        for (int i = 0; i < 3; i++) cyc(1, mkreq(3, 16'h0300 + 16'(i)), '0, '0);
        cyc(1, mkreq(4, 16'h0400), '0, '0);
        cyc(1, mkcmd(4, 3), '0, '0);
        chk("R1", "ch3 emptied by nibble 4", occ_of(3), 0);
        chk("R6", "command not stored on ch3", chan_pend[3], 0);
        chk("R6", "ch4 untouched", occ_of(4), 1);
        cyc(1, mkcmd(1, 4), '0, '0);
        chk("R6", "nibble 1 targets ch0, ch4 kept", occ_of(4), 1);
        cyc(1, mkcmd(9, 4), '0, '0);
        chk("R6", "nibble 9 stored as request", occ_of(4), 2);
        cyc(1, mkcmd(0, 4), '0, '0);
        chk("R6", "nibble 0 stored as request", occ_of(4), 3);

        // R7: software clear on ch4
        cyc(0, '0, '0, 8'h10);
        chk("R7", "clear bit set", clr_bits[4], 1);
        chk("R7", "ch4 not yet empty", occ_of(4), 3);
        idle();
        chk("R7", "clear bit self-clears", clr_bits[4], 0);
        chk("R7", "ch4 emptied", occ_of(4), 0);

        // R8: clear collides with pop and push on ch5
        cyc(1, mkreq(5, 16'h0501), '0, '0);
        cyc(1, mkreq(5, 16'h0502), '0, 8'h20);
        cyc(1, mkreq(5, 16'h0503), 8'h20, '0);
        chk("R8", "clear beats pop and push", occ_of(5), 0);
        cyc(1, mkreq(6, 16'h0601), '0, '0);
        cyc(1, mkcmd(7, 6), 8'h40, '0);
        chk("R8", "command beats pop", occ_of(6), 0);

        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] w;
            int r = $urandom_range(0, 9);
            if (r == 0) w = mkcmd($urandom_range(0, 9), $urandom_range(0, 7));
            else w = mkreq($urandom_range(0, 7), 16'(i));
            cyc($urandom_range(0, 3) != 0, w, NCH'($urandom),
                ($urandom_range(0, 15) == 0) ? (NCH'(1) << $urandom_range(0, 7)) : '0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule